// File: doc/BRIEF.md
# Two-Wire Bus Control Pattern Detector

This block watches the two open-drain lines of a two-wire serial bus, line A and line B, and sorts out the control patterns that open or manage a transfer. Both lines are asynchronous to the system clock. Each passes through a multi-flop synchroniser, and an edge detector then works on the synchronised copy. The block arms when line A is low while line B is high. From then on it counts the falling edges of line B. When line A rises, it classifies the pattern from that count.

Each outcome produces a one-cycle strobe: normal start, start with CRC, bus occupancy, bus reset, or frame error. The two start outcomes also raise `frame_open_o`, which hands the bus to a downstream bit/byte receiver. That signal stays high until the receiver pulses `frame_done_i`. While the frame is open, the detector ignores all line activity.

The controller has three states:
- `ST_IDLE` clears the counter. When A is low and B is high it takes the *arm* transition to `ST_ARMED`.
- `ST_ARMED` counts B falls. On a rising edge of A it takes the *classify* transition. This goes to `ST_FRAME` for either start outcome and to `ST_IDLE` for every other outcome.
- `ST_FRAME` takes the *release* transition back to `ST_IDLE` on `frame_done_i`.

Top module: `tw_pattern_detector`

## Requirements
- R1: While `rst_n` is low, all five strobes and `frame_open_o` are 0. Both synchronised lines read as high.
- R2: Each line passes through two synchroniser flops and one edge flop. An outcome strobe therefore rises on the third rising clock edge after the A rise is first sampled at the input.
- R3: The detector arms only when synchronised A is 0 and synchronised B is 1 in the same cycle. B falls seen while not armed are not counted, and an A rise while not armed gives no strobe.
- R4: An A rise with B high and exactly 4 counted B falls gives a one-cycle `start_o` pulse. `frame_open_o` rises in the same cycle.
- R5: An A rise with B high and exactly 6 counted falls gives a one-cycle `start_crc_o` pulse and also opens the frame.
- R6: An A rise with B high and exactly 8 counted falls gives a one-cycle `occupy_o` pulse. The frame is not opened.
- R7: An A rise with B high and 14 or more counted falls gives a one-cycle `bus_reset_o` pulse. The counter saturates at 15, so any longer run still classifies as a reset.
- R8: An A rise with B low, or with B high and a count of 0–3, 5, 7 or 9–13, gives a one-cycle `frame_err_o` pulse. The detector then returns to idle.
- R9: `frame_open_o` stays 1 until `frame_done_i` is sampled high. While it is 1, line activity produces no strobe. A `frame_done_i` pulse while the frame is closed has no effect.
- R10: At most one outcome strobe is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_a_i | input | 1 | Bus line A, asynchronous |
| line_b_i | input | 1 | Bus line B, asynchronous |
| frame_done_i | input | 1 | Byte receiver reports end of frame or error |
| start_o | output | 1 | Normal start pattern strobe |
| start_crc_o | output | 1 | Start-with-CRC pattern strobe |
| occupy_o | output | 1 | Line-B occupancy pattern strobe |
| bus_reset_o | output | 1 | Bus reset pattern strobe |
| frame_err_o | output | 1 | Malformed pattern strobe |
| frame_open_o | output | 1 | Frame handed to the byte receiver |

## Verification
A wrong count or a missed arm shows up on the classify transition. The wrong strobe, or a strobe in the wrong cycle, appears exactly three clock cycles after the A rise, because every outcome is registered. A stuck or early-released frame state shows on `frame_open_o` in the very next cycle: it either fails to drop after `frame_done_i` or drops without it. A behavioural model of the synchroniser delay and the controller is therefore compared against every output on every clock. Explicit checks are added on the latency and on the absence of strobes from unarmed activity.

// File: rtl/tw_pat_pkg.sv
package tw_pat_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_FRAME = 2'd2
    } det_state_e;

    typedef enum logic [2:0] {
        OC_NONE      = 3'd0,
        OC_START     = 3'd1,
        OC_START_CRC = 3'd2,
        OC_OCCUPY    = 3'd3,
        OC_RESET     = 3'd4,
        OC_FRAME_ERR = 3'd5
    } outcome_e;

endpackage

// File: rtl/tw_sync_edge.sv
module tw_sync_edge #(
    parameter int unsigned STAGES      = 2,
    parameter bit          DETECT_RISE = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic level_o,
    output logic edge_o
);
    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    // Open-drain lines idle high, so every flop resets to 1.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '1;
            prev_q  <= 1'b1;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], line_i};
            prev_q  <= chain_q[STAGES-1];
        end
    end

    assign level_o = chain_q[STAGES-1];

    generate
        if (DETECT_RISE) begin : g_rise
            assign edge_o = level_o & ~prev_q;
        end else begin : g_fall
            assign edge_o = ~level_o & prev_q;
        end
    endgenerate

endmodule

// File: rtl/tw_pat_counter.sv
module tw_pat_counter #(
    parameter int unsigned CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             inc_i,
    output logic [CNT_W-1:0] count_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr_i) begin
            cnt_q <= '0;
        end else if (inc_i && (cnt_q != CNT_MAX)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign count_o = cnt_q;

    // R7: a full counter holds its value instead of wrapping
    assert_no_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (count_o == CNT_MAX && inc_i && !clr_i) |=> (count_o == CNT_MAX));

    // R3: a clear request leaves the counter at zero
    assert_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (count_o == '0));

endmodule

// File: rtl/tw_pattern_detector.sv
module tw_pattern_detector #(
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned CNT_W       = 4,
    parameter int unsigned START_CNT   = 4,
    parameter int unsigned CRC_CNT     = 6,
    parameter int unsigned OCC_CNT     = 8,
    parameter int unsigned RESET_MIN   = 14
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_a_i,
    input  logic line_b_i,
    input  logic frame_done_i,
    output logic start_o,
    output logic start_crc_o,
    output logic occupy_o,
    output logic bus_reset_o,
    output logic frame_err_o,
    output logic frame_open_o
);
    import tw_pat_pkg::*;

    localparam logic [CNT_W-1:0] START_C = CNT_W'(START_CNT);
    localparam logic [CNT_W-1:0] CRC_C   = CNT_W'(CRC_CNT);
    localparam logic [CNT_W-1:0] OCC_C   = CNT_W'(OCC_CNT);
    localparam logic [CNT_W-1:0] RESET_C = CNT_W'(RESET_MIN);

    logic             a_lvl, a_rise;
    logic             b_lvl, b_fall;
    logic             cnt_clr, cnt_inc;
    logic [CNT_W-1:0] cnt;
    det_state_e       state_q, state_d;
    outcome_e         outcome;

    tw_sync_edge #(.STAGES(SYNC_STAGES), .DETECT_RISE(1'b1)) u_sync_a (
        .clk(clk), .rst_n(rst_n), .line_i(line_a_i),
        .level_o(a_lvl), .edge_o(a_rise)
    );

    tw_sync_edge #(.STAGES(SYNC_STAGES), .DETECT_RISE(1'b0)) u_sync_b (
        .clk(clk), .rst_n(rst_n), .line_i(line_b_i),
        .level_o(b_lvl), .edge_o(b_fall)
    );

    tw_pat_counter #(.CNT_W(CNT_W)) u_count (
        .clk(clk), .rst_n(rst_n), .clr_i(cnt_clr), .inc_i(cnt_inc),
        .count_o(cnt)
    );

    // Next state and outcome decision
    always_comb begin
        state_d = state_q;
        outcome = OC_NONE;
        cnt_clr = 1'b0;
        cnt_inc = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                cnt_clr = 1'b1;
                if (!a_lvl && b_lvl) begin
                    state_d = ST_ARMED;
                end
            end
            ST_ARMED: begin
                if (a_rise) begin
                    state_d = ST_IDLE;
                    if (!b_lvl) begin
                        outcome = OC_FRAME_ERR;
                    end else if (cnt == START_C) begin
                        outcome = OC_START;
                        state_d = ST_FRAME;
                    end else if (cnt == CRC_C) begin
                        outcome = OC_START_CRC;
                        state_d = ST_FRAME;
                    end else if (cnt == OCC_C) begin
                        outcome = OC_OCCUPY;
                    end else if (cnt >= RESET_C) begin
                        outcome = OC_RESET;
                    end else begin
                        outcome = OC_FRAME_ERR;
                    end
                end else begin
                    cnt_inc = b_fall;
                end
            end
            ST_FRAME: begin
                if (frame_done_i) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Registered outcome strobes
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            start_o     <= 1'b0;
            start_crc_o <= 1'b0;
            occupy_o    <= 1'b0;
            bus_reset_o <= 1'b0;
            frame_err_o <= 1'b0;
        end else begin
            start_o     <= (outcome == OC_START);
            start_crc_o <= (outcome == OC_START_CRC);
            occupy_o    <= (outcome == OC_OCCUPY);
            bus_reset_o <= (outcome == OC_RESET);
            frame_err_o <= (outcome == OC_FRAME_ERR);
        end
    end

    assign frame_open_o = (state_q == ST_FRAME);

    // R10: outcomes are mutually exclusive
    assert_onehot_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({start_o, start_crc_o, occupy_o, bus_reset_o, frame_err_o}));

    // R4: start strobe lasts one cycle and coincides with an open frame
    assert_start_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |=> !start_o);
    assert_start_opens_R4: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |-> frame_open_o);

    // R5: CRC start also opens the frame
    assert_crc_opens_R5: assert property (@(posedge clk) disable iff (!rst_n)
        start_crc_o |-> frame_open_o);

    // R6: occupancy never opens the frame
    assert_occ_closed_R6: assert property (@(posedge clk) disable iff (!rst_n)
        occupy_o |-> !frame_open_o);

    // R9: frame stays open until the receiver releases it
    assert_frame_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_open_o && !frame_done_i) |=> frame_open_o);

    // R9: no outcome while a frame is open
    assert_quiet_in_frame_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_open_o && $past(frame_open_o)) |->
            !(start_o || start_crc_o || occupy_o || bus_reset_o || frame_err_o));

endmodule

// File: tb/tw_pattern_detector_tb_top.sv
module tw_pattern_detector_tb_top;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic line_a = 1'b1;
    logic line_b = 1'b1;
    logic frame_done = 1'b0;
    logic start_s, crc_s, occ_s, rst_s, err_s, open_s;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    tw_pattern_detector dut_i (
        .clk(clk), .rst_n(rst_n), .line_a_i(line_a), .line_b_i(line_b),
        .frame_done_i(frame_done),
        .start_o(start_s), .start_crc_o(crc_s), .occupy_o(occ_s),
        .bus_reset_o(rst_s), .frame_err_o(err_s), .frame_open_o(open_s)
    );

    task automatic chk(input logic act, input logic exp, input string req, input string what);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0b expected %0b at %0t", req, what, act, exp, $time);
        end
    endtask

    // Behavioural reference: line delay queues plus pattern classifier
    bit qa[$];
    bit qb[$];
    int m_state = 0;   // 0 idle, 1 armed, 2 frame
    int m_cnt   = 0;
    bit e_start, e_crc, e_occ, e_rst, e_err, e_open;

    always @(posedge clk) begin
        if (!rst_n) begin
            qa = '{1'b1, 1'b1, 1'b1};
            qb = '{1'b1, 1'b1, 1'b1};
            m_state = 0; m_cnt = 0;
            {e_start, e_crc, e_occ, e_rst, e_err, e_open} = '0;
        end else begin
            bit ca, pa, cb, pb, rise_a, fall_b;
            qa.push_back(line_a);
            qb.push_back(line_b);
            pa = qa[0]; ca = qa[1];
            pb = qb[0]; cb = qb[1];
            void'(qa.pop_front());
            void'(qb.pop_front());
            rise_a = ca && !pa;
            fall_b = pb && !cb;
            {e_start, e_crc, e_occ, e_rst, e_err} = '0;
            case (m_state)
                0: begin
                    m_cnt = 0;
                    if (!ca && cb) m_state = 1;
                end
                1: begin
                    if (rise_a) begin
                        m_state = 0;
                        if (!cb) e_err = 1;
                        else if (m_cnt == 4) begin e_start = 1; m_state = 2; end
                        else if (m_cnt == 6) begin e_crc = 1; m_state = 2; end
                        else if (m_cnt == 8) e_occ = 1;
                        else if (m_cnt >= 14) e_rst = 1;
                        else e_err = 1;
                    end else if (fall_b && m_cnt < 15) begin
                        m_cnt++;
                    end
                end
                default: begin
                    if (frame_done) m_state = 0;
                end
            endcase
            e_open = (m_state == 2);
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            chk(start_s, e_start, "R4", "start_o");
            chk(crc_s,   e_crc,   "R5", "start_crc_o");
            chk(occ_s,   e_occ,   "R6", "occupy_o");
            chk(rst_s,   e_rst,   "R7", "bus_reset_o");
            chk(err_s,   e_err,   "R8", "frame_err_o");
            chk(open_s,  e_open,  "R9", "frame_open_o");
            chk(($countones({start_s, crc_s, occ_s, rst_s, err_s}) <= 1), 1'b1, "R10", "onehot");
        end
    end

    task automatic hold(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic any_strobe();
        return start_s | crc_s | occ_s | rst_s | err_s;
    endfunction

    // Drives one control pattern; checks the R2 latency of the strobe
    task automatic send_pattern(input int falls, input bit b_end);
        int first;
        line_a = 1; line_b = 1; hold(5);
        line_a = 0; hold(4);
        for (int i = 0; i < falls; i++) begin
            line_b = 0; hold(2);
            line_b = 1; hold(2);
        end
        if (!b_end) begin line_b = 0; hold(3); end
        line_a = 1;
        first = 0;
        for (int i = 1; i <= 5; i++) begin
            @(negedge clk);
            if (first == 0 && any_strobe()) first = i;
        end
        checks++;
        if (first != 3) begin
            fails++;
            $display("FAIL R2 strobe latency: actual %0d expected 3", first);
        end
        line_b = 1; hold(3);
        if (open_s) begin
            // line activity inside an open frame must be ignored (R9)
            line_a = 0; hold(3); line_b = 0; hold(2); line_b = 1; hold(2);
            line_a = 1; hold(4);
            frame_done = 1; hold(1); frame_done = 0; hold(2);
        end
    endtask

    initial begin
        int seen;
        hold(4);
        // R1: reset state
        chk(start_s | crc_s | occ_s | rst_s | err_s, 1'b0, "R1", "strobes in reset");
        chk(open_s, 1'b0, "R1", "frame_open in reset");
        rst_n = 1; hold(3);

        // R3: A low with B low is not an arm; B toggles with A high not counted
        seen = 0;
        line_a = 0; line_b = 0;
        for (int i = 0; i < 6; i++) begin @(negedge clk); if (any_strobe()) seen++; end
        line_a = 1;
        for (int i = 0; i < 6; i++) begin @(negedge clk); if (any_strobe()) seen++; end
        line_b = 1;
        for (int k = 0; k < 3; k++) begin
            line_b = 0; @(negedge clk); if (any_strobe()) seen++;
            line_b = 1; @(negedge clk); if (any_strobe()) seen++;
        end
        hold(3);
        checks++;
        if (seen != 0) begin
            fails++;
            $display("FAIL R3 unarmed strobes: actual %0d expected 0", seen);
        end

        send_pattern(4, 1);    // R4 start
        send_pattern(6, 1);    // R5 start with CRC
        send_pattern(8, 1);    // R6 occupancy
        send_pattern(14, 1);   // R7 reset at threshold
        send_pattern(15, 1);   // R7
        send_pattern(20, 1);   // R7 saturation
        send_pattern(0, 1);    // R8
        send_pattern(3, 1);    // R8
        send_pattern(5, 1);    // R8
        send_pattern(7, 1);    // R8
        send_pattern(10, 1);   // R8
        send_pattern(13, 1);   // R8
        send_pattern(4, 0);    // R8 B low at end

        // R9: release pulse while closed has no effect
        frame_done = 1; hold(1); frame_done = 0; hold(2);
        chk(open_s, 1'b0, "R9", "frame_open after idle release");
        send_pattern(6, 1);    // R5 after idle release

        hold(5);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule